// File: doc/BRIEF.md
# AXI-Lite Data Width Upsizer

This block joins a narrow AXI-Lite port, driven by an upstream manager, to a wider AXI-Lite port that faces a downstream subordinate. The wide data width is a power-of-two multiple of the narrow width. Addresses on the write-address and read-address channels pass through untouched. Each narrow write beat is copied into every lane of the wide data bus, and its byte strobes are moved into the one lane that the write address selects. Each wide read beat is cut down to the lane that the matching read address selected. Response codes on both the write-response and read-data channels are forwarded as they are.

The lane index is the address field of width log2(wide/narrow) that starts just above the narrow-word byte offset. With the defaults (32-bit narrow, 128-bit wide) this is address bits [3:2]. Write lanes come from a single-entry slot: an accepted write address holds its lane until its data beat completes. Read lanes sit in a first-in, first-out queue. Each returning read beat therefore uses the lane of the oldest read request that is still open.

All five channels use valid/ready handshakes, and every path through the block is combinational. A transfer completes in a cycle where valid and ready are both high. Back-pressure flows straight through: a ready on one side is the other side's ready, gated only by the block's own slot and queue state. The block never withdraws a valid it has raised, provided its neighbours keep their own valids and payloads steady while stalled. It adds no cycles of latency. It only holds a write address off while the write slot is taken and not being freed, holds a read address off while the read queue is full, and holds read data back while the queue is empty.

Top module: `lite_width_upsizer`

## Requirements
- R1: The wide write-address channel carries the narrow write address unchanged in the same cycle. The write address is accepted only when the write slot is empty, or when the write-data beat that frees the slot completes in that same cycle.
- R2: Every NARROW_W-bit lane of the outgoing wide write data equals the incoming narrow write data, so lane 0 (the lowest bits) always equals it.
- R3: The outgoing write strobe equals the narrow strobe shifted left by lane × (NARROW_W/8). The lane is taken from address bits [log2(NARROW_W/8) +: log2(WIDE_W/NARROW_W)] of the write address that owns the slot. All other lanes carry zero strobes.
- R4: No write-data beat is forwarded while the write slot is empty; after reset the slot is empty. The slot is filled on a write-address handshake and cleared on a write-data handshake.
- R5: The write response (valid, ready, 2-bit code) passes between the two ports unchanged and in the same cycle.
- R6: The wide read-address channel carries the narrow read address unchanged. A read address is accepted only while fewer than RQ_DEPTH read requests are open.
- R7: The returned narrow read data equals the wide read data shifted right by lane × NARROW_W and truncated to NARROW_W. The read response code is passed back unchanged. Lanes are used in the order the read addresses were accepted.
- R8: No read beat is forwarded, and the wide read-data ready stays low, while no read request is open. After reset no request is open.
- R9: Once the block raises a valid toward either port, that valid stays high until its handshake completes, provided the block's neighbours obey the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nar_aw_valid | input | 1 | Narrow write address valid |
| nar_aw_ready | output | 1 | Narrow write address ready |
| nar_aw_addr | input | ADDR_W | Narrow write address |
| nar_w_valid | input | 1 | Narrow write data valid |
| nar_w_ready | output | 1 | Narrow write data ready |
| nar_w_data | input | NARROW_W | Narrow write data |
| nar_w_strb | input | NARROW_W/8 | Narrow write byte strobes |
| nar_b_valid | output | 1 | Narrow write response valid |
| nar_b_ready | input | 1 | Narrow write response ready |
| nar_b_resp | output | 2 | Narrow write response code |
| nar_ar_valid | input | 1 | Narrow read address valid |
| nar_ar_ready | output | 1 | Narrow read address ready |
| nar_ar_addr | input | ADDR_W | Narrow read address |
| nar_r_valid | output | 1 | Narrow read data valid |
| nar_r_ready | input | 1 | Narrow read data ready |
| nar_r_data | output | NARROW_W | Narrow read data |
| nar_r_resp | output | 2 | Narrow read response code |
| wid_aw_valid | output | 1 | Wide write address valid |
| wid_aw_ready | input | 1 | Wide write address ready |
| wid_aw_addr | output | ADDR_W | Wide write address |
| wid_w_valid | output | 1 | Wide write data valid |
| wid_w_ready | input | 1 | Wide write data ready |
| wid_w_data | output | WIDE_W | Wide write data |
| wid_w_strb | output | WIDE_W/8 | Wide write byte strobes |
| wid_b_valid | input | 1 | Wide write response valid |
| wid_b_ready | output | 1 | Wide write response ready |
| wid_b_resp | input | 2 | Wide write response code |
| wid_ar_valid | output | 1 | Wide read address valid |
| wid_ar_ready | input | 1 | Wide read address ready |
| wid_ar_addr | output | ADDR_W | Wide read address |
| wid_r_valid | input | 1 | Wide read data valid |
| wid_r_ready | output | 1 | Wide read data ready |
| wid_r_data | input | WIDE_W | Wide read data |
| wid_r_resp | input | 2 | Wide read response code |

## Verification
Every output depends combinationally on the inputs in the same cycle and on slot and queue state. That state changes only at the clock edge that ends a handshake. The bench therefore drives inputs just after a rising edge and compares every output with its model at the following falling edge. It applies the handshakes it saw there to the model at the next rising edge, so a write lane or read lane first matters in the cycle after its address handshake. Directed phases fill the read queue to its limit and then drain it, and others starve or flood the write-data channel, so that the boundaries of the queue and the slot are reached.

// File: rtl/lite_up_pkg.sv
package lite_up_pkg;
  localparam int unsigned RESP_W = 2;
  typedef logic [RESP_W-1:0] lite_resp_t;

  // number of address bits addressing bytes inside one narrow word
  function automatic int unsigned byte_off_bits(input int unsigned narrow_w);
    return $clog2(narrow_w / 8);
  endfunction

  // number of address bits picking one narrow lane of the wide bus
  function automatic int unsigned lane_bits(input int unsigned narrow_w, input int unsigned wide_w);
    return (wide_w / narrow_w > 1) ? $clog2(wide_w / narrow_w) : 1;
  endfunction
endpackage

// File: rtl/lite_up_lane_fifo.sv
module lite_up_lane_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/lite_up_wpath.sv
module lite_up_wpath #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nar_aw_valid,
  output logic                  nar_aw_ready,
  input  logic [ADDR_W-1:0]     nar_aw_addr,
  input  logic                  nar_w_valid,
  output logic                  nar_w_ready,
  input  logic [NARROW_W-1:0]   nar_w_data,
  input  logic [NARROW_W/8-1:0] nar_w_strb,
  output logic                  wid_aw_valid,
  input  logic                  wid_aw_ready,
  output logic [ADDR_W-1:0]     wid_aw_addr,
  output logic                  wid_w_valid,
  input  logic                  wid_w_ready,
  output logic [WIDE_W-1:0]     wid_w_data,
  output logic [WIDE_W/8-1:0]   wid_w_strb
);
  localparam int unsigned NB    = NARROW_W / 8;
  localparam int unsigned RATIO = WIDE_W / NARROW_W;
  localparam int unsigned SEL_W = lite_up_pkg::lane_bits(NARROW_W, WIDE_W);
  localparam int unsigned OFF   = lite_up_pkg::byte_off_bits(NARROW_W);

  logic             slot_vld;
  logic [SEL_W-1:0] slot_lane;
  logic             aw_fire, w_fire, slot_free;

  assign wid_w_valid = nar_w_valid & slot_vld;
  assign nar_w_ready = wid_w_ready & slot_vld;
  assign w_fire      = wid_w_valid & wid_w_ready;
  assign slot_free   = ~slot_vld | w_fire;

  assign wid_aw_valid = nar_aw_valid & slot_free;
  assign nar_aw_ready = wid_aw_ready & slot_free;
  assign wid_aw_addr  = nar_aw_addr;
  assign aw_fire      = nar_aw_valid & nar_aw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld  <= 1'b0;
      slot_lane <= '0;
    end else if (aw_fire) begin
      slot_vld  <= 1'b1;
      slot_lane <= nar_aw_addr[OFF +: SEL_W];
    end else if (w_fire) begin
      slot_vld  <= 1'b0;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    assign wid_w_data[g*NARROW_W +: NARROW_W] = nar_w_data;
    assign wid_w_strb[g*NB +: NB] = (slot_lane == SEL_W'(g)) ? nar_w_strb : '0;
  end
endmodule

// File: rtl/lite_up_rpath.sv
module lite_up_rpath #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  parameter int unsigned RQ_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       nar_ar_valid,
  output logic                       nar_ar_ready,
  input  logic [ADDR_W-1:0]          nar_ar_addr,
  output logic                       nar_r_valid,
  input  logic                       nar_r_ready,
  output logic [NARROW_W-1:0]        nar_r_data,
  output lite_up_pkg::lite_resp_t    nar_r_resp,
  output logic                       wid_ar_valid,
  input  logic                       wid_ar_ready,
  output logic [ADDR_W-1:0]          wid_ar_addr,
  input  logic                       wid_r_valid,
  output logic                       wid_r_ready,
  input  logic [WIDE_W-1:0]          wid_r_data,
  input  lite_up_pkg::lite_resp_t    wid_r_resp
);
  localparam int unsigned RATIO = WIDE_W / NARROW_W;
  localparam int unsigned SEL_W = lite_up_pkg::lane_bits(NARROW_W, WIDE_W);
  localparam int unsigned OFF   = lite_up_pkg::byte_off_bits(NARROW_W);

  logic             q_full, q_empty, ar_fire, r_fire;
  logic [SEL_W-1:0] q_head;
  logic [NARROW_W-1:0] slice [RATIO];

  assign wid_ar_valid = nar_ar_valid & ~q_full;
  assign nar_ar_ready = wid_ar_ready & ~q_full;
  assign wid_ar_addr  = nar_ar_addr;
  assign ar_fire      = nar_ar_valid & nar_ar_ready;

  assign nar_r_valid  = wid_r_valid & ~q_empty;
  assign wid_r_ready  = nar_r_ready & ~q_empty;
  assign r_fire       = wid_r_valid & wid_r_ready;
  assign nar_r_resp   = wid_r_resp;

  lite_up_lane_fifo #(.DEPTH(RQ_DEPTH), .W(SEL_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ar_fire),
    .push_data (nar_ar_addr[OFF +: SEL_W]),
    .pop       (r_fire),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  for (genvar g = 0; g < RATIO; g++) begin : g_slice
    assign slice[g] = wid_r_data[g*NARROW_W +: NARROW_W];
  end

  assign nar_r_data = slice[q_head];
endmodule

// File: rtl/lite_width_upsizer.sv
module lite_width_upsizer #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  parameter int unsigned RQ_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nar_aw_valid,
  output logic                  nar_aw_ready,
  input  logic [ADDR_W-1:0]     nar_aw_addr,
  input  logic                  nar_w_valid,
  output logic                  nar_w_ready,
  input  logic [NARROW_W-1:0]   nar_w_data,
  input  logic [NARROW_W/8-1:0] nar_w_strb,
  output logic                  nar_b_valid,
  input  logic                  nar_b_ready,
  output logic [1:0]            nar_b_resp,
  input  logic                  nar_ar_valid,
  output logic                  nar_ar_ready,
  input  logic [ADDR_W-1:0]     nar_ar_addr,
  output logic                  nar_r_valid,
  input  logic                  nar_r_ready,
  output logic [NARROW_W-1:0]   nar_r_data,
  output logic [1:0]            nar_r_resp,
  output logic                  wid_aw_valid,
  input  logic                  wid_aw_ready,
  output logic [ADDR_W-1:0]     wid_aw_addr,
  output logic                  wid_w_valid,
  input  logic                  wid_w_ready,
  output logic [WIDE_W-1:0]     wid_w_data,
  output logic [WIDE_W/8-1:0]   wid_w_strb,
  input  logic                  wid_b_valid,
  output logic                  wid_b_ready,
  input  logic [1:0]            wid_b_resp,
  output logic                  wid_ar_valid,
  input  logic                  wid_ar_ready,
  output logic [ADDR_W-1:0]     wid_ar_addr,
  input  logic                  wid_r_valid,
  output logic                  wid_r_ready,
  input  logic [WIDE_W-1:0]     wid_r_data,
  input  logic [1:0]            wid_r_resp
);
  // write response: straight pass in both directions
  assign nar_b_valid = wid_b_valid;
  assign wid_b_ready = nar_b_ready;
  assign nar_b_resp  = wid_b_resp;

  lite_up_wpath #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_wpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .nar_aw_valid (nar_aw_valid),
    .nar_aw_ready (nar_aw_ready),
    .nar_aw_addr  (nar_aw_addr),
    .nar_w_valid  (nar_w_valid),
    .nar_w_ready  (nar_w_ready),
    .nar_w_data   (nar_w_data),
    .nar_w_strb   (nar_w_strb),
    .wid_aw_valid (wid_aw_valid),
    .wid_aw_ready (wid_aw_ready),
    .wid_aw_addr  (wid_aw_addr),
    .wid_w_valid  (wid_w_valid),
    .wid_w_ready  (wid_w_ready),
    .wid_w_data   (wid_w_data),
    .wid_w_strb   (wid_w_strb)
  );

  lite_up_rpath #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
                  .RQ_DEPTH(RQ_DEPTH)) u_rpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .nar_ar_valid (nar_ar_valid),
    .nar_ar_ready (nar_ar_ready),
    .nar_ar_addr  (nar_ar_addr),
    .nar_r_valid  (nar_r_valid),
    .nar_r_ready  (nar_r_ready),
    .nar_r_data   (nar_r_data),
    .nar_r_resp   (nar_r_resp),
    .wid_ar_valid (wid_ar_valid),
    .wid_ar_ready (wid_ar_ready),
    .wid_ar_addr  (wid_ar_addr),
    .wid_r_valid  (wid_r_valid),
    .wid_r_ready  (wid_r_ready),
    .wid_r_data   (wid_r_data),
    .wid_r_resp   (wid_r_resp)
  );
endmodule

// File: rtl/lite_width_upsizer_chk.sv
module lite_width_upsizer_chk #(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  parameter int unsigned RQ_DEPTH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                nar_aw_valid,
  input logic                nar_aw_ready,
  input logic                nar_w_valid,
  input logic                nar_w_ready,
  input logic                nar_ar_valid,
  input logic                nar_ar_ready,
  input logic                nar_r_valid,
  input logic                nar_r_ready,
  input logic                wid_aw_valid,
  input logic                wid_aw_ready,
  input logic                wid_w_valid,
  input logic                wid_w_ready,
  input logic [WIDE_W/8-1:0] wid_w_strb,
  input logic                wid_ar_valid,
  input logic                wid_ar_ready,
  input logic                wid_r_valid
);
  localparam int unsigned NB    = NARROW_W / 8;
  localparam int unsigned RATIO = WIDE_W / NARROW_W;
  localparam int unsigned CNT_W = $clog2(RQ_DEPTH + 2);

  logic [RATIO-1:0] lane_hit;
  logic [CNT_W-1:0] open_rd;

  for (genvar g = 0; g < RATIO; g++) begin : g_hit
    assign lane_hit[g] = |wid_w_strb[g*NB +: NB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_rd <= '0;
    else case ({nar_ar_valid & nar_ar_ready, nar_r_valid & nar_r_ready})
      2'b10:   open_rd <= open_rd + 1'b1;
      2'b01:   open_rd <= open_rd - 1'b1;
      default: open_rd <= open_rd;
    endcase
  end

  // R1
  aw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_aw_valid && nar_aw_ready) |-> (wid_aw_valid && wid_aw_ready));

  // R3
  strb_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wid_w_valid |-> $onehot0(lane_hit));

  // R4
  w_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_w_valid && nar_w_ready) |-> (wid_w_valid && wid_w_ready));

  // R6
  rd_open_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_rd <= CNT_W'(RQ_DEPTH));

  // R8
  r_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nar_r_valid |-> (wid_r_valid && open_rd != '0));

  // R9
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wid_ar_valid && !wid_ar_ready && nar_ar_valid) |=> wid_ar_valid);

  // R9
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wid_aw_valid && !wid_aw_ready && nar_aw_valid) |=> wid_aw_valid);
endmodule

bind lite_width_upsizer lite_width_upsizer_chk #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .RQ_DEPTH(RQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .nar_aw_valid(nar_aw_valid), .nar_aw_ready(nar_aw_ready),
  .nar_w_valid(nar_w_valid), .nar_w_ready(nar_w_ready),
  .nar_ar_valid(nar_ar_valid), .nar_ar_ready(nar_ar_ready),
  .nar_r_valid(nar_r_valid), .nar_r_ready(nar_r_ready),
  .wid_aw_valid(wid_aw_valid), .wid_aw_ready(wid_aw_ready),
  .wid_w_valid(wid_w_valid), .wid_w_ready(wid_w_ready),
  .wid_w_strb(wid_w_strb),
  .wid_ar_valid(wid_ar_valid), .wid_ar_ready(wid_ar_ready),
  .wid_r_valid(wid_r_valid)
);

// File: tb/tb_lite_width_upsizer.sv
`timescale 1ns/1ps
module tb_lite_width_upsizer;
  localparam int AW = 32, NW = 32, WW = 128, DEPTH = 4;
  localparam int NB = NW / 8, RATIO = WW / NW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          nar_aw_valid = 0, nar_aw_ready; logic [AW-1:0] nar_aw_addr = 0;
  logic          nar_w_valid = 0, nar_w_ready;   logic [NW-1:0] nar_w_data = 0;
  logic [NB-1:0] nar_w_strb = 0;
  logic          nar_b_valid, nar_b_ready = 0;   logic [1:0] nar_b_resp;
  logic          nar_ar_valid = 0, nar_ar_ready; logic [AW-1:0] nar_ar_addr = 0;
  logic          nar_r_valid, nar_r_ready = 0;   logic [NW-1:0] nar_r_data;
  logic [1:0]    nar_r_resp;
  logic          wid_aw_valid, wid_aw_ready = 0; logic [AW-1:0] wid_aw_addr;
  logic          wid_w_valid, wid_w_ready = 0;   logic [WW-1:0] wid_w_data;
  logic [WW/8-1:0] wid_w_strb;
  logic          wid_b_valid = 0, wid_b_ready;   logic [1:0] wid_b_resp = 0;
  logic          wid_ar_valid, wid_ar_ready = 0; logic [AW-1:0] wid_ar_addr;
  logic          wid_r_valid = 0, wid_r_ready;   logic [WW-1:0] wid_r_data = 0;
  logic [1:0]    wid_r_resp = 0;

  lite_width_upsizer #(.ADDR_W(AW), .NARROW_W(NW), .WIDE_W(WW), .RQ_DEPTH(DEPTH)) dut (.*);

  int total = 0, bad = 0;
  bit done = 0;
  int p_aw = 70, p_w = 70, p_ar = 70, p_r = 70, p_b = 70, p_rdy = 70, p_wrdy = 70;
  int wq[$];
  int rq[$];
  bit aw_hs, w_hs, b_hs, ar_hs, r_hs;
  bit prev_awv_stall, prev_arv_stall;

  function automatic bit roll(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, checked at every falling edge
  task automatic check_cycle();
    bit slot, wv, free, full, have;
    logic [WW-1:0] exp_wd;
    logic [WW/8-1:0] exp_ws;
    logic [NW-1:0] exp_rd;
    slot = (wq.size() > 0);
    wv   = nar_w_valid && slot;
    free = !slot || (wv && wid_w_ready);
    for (int i = 0; i < RATIO; i++) exp_wd[i*NW +: NW] = nar_w_data;
    exp_ws = slot ? ((WW/8)'(nar_w_strb) << (wq[0] * NB)) : '0;
    full = (rq.size() == DEPTH);
    have = (rq.size() > 0);
    exp_rd = have ? NW'(wid_r_data >> (rq[0] * NW)) : '0;

    chk(wid_aw_valid == (nar_aw_valid && free) && nar_aw_ready == (wid_aw_ready && free)
        && wid_aw_addr == nar_aw_addr, "R1", "aw",
        {wid_aw_valid, nar_aw_ready, wid_aw_addr}, {nar_aw_valid && free, wid_aw_ready && free, nar_aw_addr});
    chk(wid_w_data == exp_wd && wid_w_data[NW-1:0] == nar_w_data, "R2", "wdata", wid_w_data, exp_wd);
    if (slot) chk(wid_w_strb == exp_ws, "R3", "wstrb", wid_w_strb, exp_ws);
    chk(wid_w_valid == wv && nar_w_ready == (wid_w_ready && slot), "R4", "w hs",
        {wid_w_valid, nar_w_ready}, {wv, wid_w_ready && slot});
    chk(nar_b_valid == wid_b_valid && wid_b_ready == nar_b_ready && nar_b_resp == wid_b_resp,
        "R5", "b", {nar_b_valid, wid_b_ready, nar_b_resp}, {wid_b_valid, nar_b_ready, wid_b_resp});
    chk(wid_ar_valid == (nar_ar_valid && !full) && nar_ar_ready == (wid_ar_ready && !full)
        && wid_ar_addr == nar_ar_addr, "R6", "ar",
        {wid_ar_valid, nar_ar_ready, wid_ar_addr}, {nar_ar_valid && !full, wid_ar_ready && !full, nar_ar_addr});
    chk(nar_r_valid == (wid_r_valid && have) && wid_r_ready == (nar_r_ready && have), "R8", "r hs",
        {nar_r_valid, wid_r_ready}, {wid_r_valid && have, nar_r_ready && have});
    if (have && wid_r_valid)
      chk(nar_r_data == exp_rd && nar_r_resp == wid_r_resp, "R7", "rdata",
          {nar_r_resp, nar_r_data}, {wid_r_resp, exp_rd});
    if (prev_awv_stall) chk(wid_aw_valid, "R9", "aw valid kept", wid_aw_valid, 1);
    if (prev_arv_stall) chk(wid_ar_valid, "R9", "ar valid kept", wid_ar_valid, 1);

    aw_hs = nar_aw_valid && wid_aw_ready && free;
    w_hs  = wv && wid_w_ready;
    b_hs  = wid_b_valid && nar_b_ready;
    ar_hs = nar_ar_valid && wid_ar_ready && !full;
    r_hs  = wid_r_valid && nar_r_ready && have;
    prev_awv_stall = (nar_aw_valid && free) && !wid_aw_ready;
    prev_arv_stall = (nar_ar_valid && !full) && !wid_ar_ready;
  endtask

  task automatic step();
    @(negedge clk);
    check_cycle();
    @(posedge clk);
    #1;
    if (w_hs) void'(wq.pop_front());
    if (aw_hs) wq.push_back(int'(nar_aw_addr[3:2]));
    if (r_hs) void'(rq.pop_front());
    if (ar_hs) rq.push_back(int'(nar_ar_addr[3:2]));
    if (!nar_aw_valid || aw_hs) begin nar_aw_valid = roll(p_aw); nar_aw_addr = $urandom; end
    if (!nar_w_valid || w_hs) begin nar_w_valid = roll(p_w); nar_w_data = $urandom; nar_w_strb = NB'($urandom); end
    if (!nar_ar_valid || ar_hs) begin nar_ar_valid = roll(p_ar); nar_ar_addr = $urandom; end
    if (!wid_b_valid || b_hs) begin wid_b_valid = roll(p_b); wid_b_resp = 2'($urandom); end
    if (!wid_r_valid || r_hs) begin
      wid_r_valid = roll(p_r); wid_r_resp = 2'($urandom);
      wid_r_data = {$urandom, $urandom, $urandom, $urandom};
    end
    wid_aw_ready = roll(p_rdy); wid_w_ready = roll(p_wrdy); wid_ar_ready = roll(p_rdy);
    nar_b_ready = roll(p_rdy); nar_r_ready = roll(p_rdy);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // reset state, valids high on all inbound sides
    nar_w_valid = 1; wid_r_valid = 1; nar_r_ready = 1; wid_w_ready = 1;
    #1;
    chk(!wid_w_valid && !nar_w_ready, "R4", "w blocked in reset state", wid_w_valid, 0);
    chk(!nar_r_valid && !wid_r_ready, "R8", "r blocked in reset state", nar_r_valid, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(!wid_w_valid, "R4", "w blocked before first aw", wid_w_valid, 0);
    chk(!nar_r_valid, "R8", "r blocked before first ar", nar_r_valid, 0);
    repeat (400) step();
    // fill read queue: no read data returns
    p_r = 0; p_ar = 100; p_rdy = 100;
    wid_r_valid = 0;
    repeat (40) step();
    chk(rq.size() == DEPTH && !nar_ar_ready, "R6", "queue full stalls ar", nar_ar_ready, 0);
    // drain it
    p_ar = 0; p_r = 100;
    repeat (40) step();
    chk(rq.size() == 0 && !nar_r_valid, "R8", "queue empty blocks r", nar_r_valid, 0);
    // write data starved, then flooded
    p_ar = 70; p_r = 70; p_rdy = 70; p_w = 0;
    repeat (60) step();
    p_w = 100; p_wrdy = 10;
    repeat (200) step();
    p_wrdy = 100; p_aw = 100;
    repeat (200) step();
    p_aw = 70; p_wrdy = 70;
    repeat (2000) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule